// File: doc/BRIEF.md
# Bit-Serial Shift and Rotate Unit

This execution unit shifts or rotates an 8-bit or 16-bit operand. A count greater than one runs as that many single-bit steps, one step per clock. The carry passes from each step into the next. When the last step is done, the unit gives back the shifted value, the final carry flag and an overflow flag. The overflow flag shows whether the sign bit of the result differs from the sign bit the operand had before the first step.

A caller applies the operand, the width select, the operation code, the count source, the incoming carry and the incoming overflow. It then pulses `start` for one cycle. `busy` stays high while steps are in progress. `done` pulses for one cycle once the final result is in the output registers. The outputs keep their values until the next operation is accepted. The unit does not fetch operands and does not write results back.

Top module: `bitstep_shifter`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `result`, `cf_out` and `of_out` are all 0.
- R2: If `cnt_from_reg` is 0, exactly one step runs and `reg_count` is ignored. If it is 1, the step count is `reg_count[4:0]`, so 0 to 31 steps, and bits 7:5 of `reg_count` are ignored.
- R3: Let the edge that samples `start` in the idle state be edge 0. For a count of N, `done` is high for exactly one cycle, and that cycle follows edge N. `busy` is high in the cycles after edges 0 to N-1 and low while `done` is high.
- R4: Op 0 rotates left and op 1 rotates right. The bit that leaves one end is placed at the other end and is also copied into CF.
- R5: Op 2 rotates left through carry: the top bit moves into CF and the old CF enters bit 0. Op 3 is the mirror: bit 0 moves into CF and the old CF enters the top bit. Example: 1Ch with CF=1 gives 39h and CF=0 for op 2, and 8Eh and CF=0 for op 3.
- R6: Ops 4 and 6 both shift left. Bit 0 is filled with 0 and CF takes the top bit. Example: E0h gives C0h and CF=1.
- R7: Op 5 shifts right and fills the top bit with 0. Op 7 shifts right and keeps the sign bit. In both, CF takes bit 0. Examples: 4Ch gives 26h with op 5, and E0h gives F0h with CF=0 with op 7.
- R8: After a count of one or more, `of_out` is 1 exactly when the sign bit of the result differs from the sign bit of the operand as it was at `start`. The sign bit is bit 7 in byte mode and bit 15 in word mode.
- R9: A count of 0 finishes with `result` equal to the operand, `cf_out` equal to `carry_in` and `of_out` equal to `ovf_in`.
- R10: When `wide` is 0, only `operand[7:0]` takes part in the operation and `result[15:8]` is 0.
- R11: A `start` pulse while an operation is in progress is ignored, and the result of the running operation is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the inputs and begin an operation (used only when idle) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| op | input | 3 | Operation code (see R4 to R7) |
| cnt_from_reg | input | 1 | 1 = take the count from `reg_count`, 0 = count of one |
| reg_count | input | 8 | Count register value; only the low 5 bits are used |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag, passed through when the count is 0 |
| operand | input | 16 | Value to shift or rotate |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse: result and flags are final |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | Final carry flag |
| of_out | output | 1 | Final overflow flag |

## Verification
The main function is driven with single-step vectors of every operation code in both widths. These separate the fill source of each operation: zero, sign, wrap-around bit or old carry. Multi-step counts are also run. Among them are 9 left shifts in byte mode, which push a 1 out and then a 0. A 17-step rotate through carry on a word returns the operand intact, so an error in threading the carry would show. A register count of FFh must be cut to 31, and 20h must become a zero count that passes the flags through. Operands with the upper byte set, given in byte mode, show whether the width select really masks the upper bits. The done latency is measured for each vector, and this separates the fixed single-step count from the count taken from the register.

// File: rtl/bitstep_pkg.sv
package bitstep_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'd0,
        OP_ROR = 3'd1,
        OP_RCL = 3'd2,
        OP_RCR = 3'd3,
        OP_SHL = 3'd4,
        OP_SHR = 3'd5,
        OP_SAL = 3'd6,
        OP_SAR = 3'd7
    } shop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/bitstep_count_sel.sv
module bitstep_count_sel #(
    parameter int RW = 8,
    parameter int CW = 5
) (
    input  logic          cnt_from_reg,
    input  logic [RW-1:0] reg_count,
    output logic [CW-1:0] steps
);
    logic unused_high;
    assign unused_high = ^reg_count[RW-1:CW];

    always_comb begin
        if (cnt_from_reg) steps = reg_count[CW-1:0];
        else              steps = CW'(1);
    end
endmodule

// File: rtl/bitstep_one.sv
module bitstep_one
    import bitstep_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 8
) (
    input  logic [DW-1:0] val,
    input  logic          wide,
    input  shop_e         op,
    input  logic          cin,
    output logic [DW-1:0] val_n,
    output logic          cout,
    output logic          msb_n
);
    logic          top_b;
    logic          bot_b;
    logic          fill;
    logic          go_left;
    logic [DW-1:0] left_v;
    logic [DW-1:0] right_v;

    always_comb begin
        top_b   = wide ? val[DW-1] : val[NW-1];
        bot_b   = val[0];
        go_left = (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
        unique case (op)
            OP_ROL:          fill = top_b;
            OP_ROR:          fill = bot_b;
            OP_RCL, OP_RCR:  fill = cin;
            OP_SAR:          fill = top_b;
            default:         fill = 1'b0;
        endcase

        left_v = {val[DW-2:0], fill};
        if (!wide) left_v[DW-1:NW] = '0;

        if (wide) right_v = {fill, val[DW-1:1]};
        else      right_v = {{(DW-NW){1'b0}}, fill, val[NW-1:1]};

        val_n = go_left ? left_v : right_v;
        cout  = go_left ? top_b : bot_b;
        msb_n = wide ? val_n[DW-1] : val_n[NW-1];
    end
endmodule

// File: rtl/bitstep_shifter.sv
module bitstep_shifter
    import bitstep_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 8,
    parameter int RW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide,
    input  logic [2:0]    op,
    input  logic          cnt_from_reg,
    input  logic [RW-1:0] reg_count,
    input  logic          carry_in,
    input  logic          ovf_in,
    input  logic [DW-1:0] operand,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          cf_out,
    output logic          of_out
);
    typedef struct packed {
        phase_e        phase;
        logic [DW-1:0] val;
        logic          cf;
        logic          of;
        logic          sign0;
        logic [CW-1:0] rem;
        shop_e         op;
        logic          wide;
    } core_t;

    core_t cur_q;
    core_t nxt_d;

    logic [CW-1:0] steps_d;
    logic [DW-1:0] step_val_d;
    logic          step_cf_d;
    logic          step_msb_d;

    bitstep_count_sel #(.RW(RW), .CW(CW)) u_cnt (
        .cnt_from_reg (cnt_from_reg),
        .reg_count    (reg_count),
        .steps        (steps_d)
    );

    bitstep_one #(.DW(DW), .NW(NW)) u_step (
        .val   (cur_q.val),
        .wide  (cur_q.wide),
        .op    (cur_q.op),
        .cin   (cur_q.cf),
        .val_n (step_val_d),
        .cout  (step_cf_d),
        .msb_n (step_msb_d)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.val   = wide ? operand : {{(DW-NW){1'b0}}, operand[NW-1:0]};
                    nxt_d.cf    = carry_in;
                    nxt_d.of    = ovf_in;
                    nxt_d.sign0 = wide ? operand[DW-1] : operand[NW-1];
                    nxt_d.rem   = steps_d;
                    nxt_d.op    = shop_e'(op);
                    nxt_d.wide  = wide;
                    nxt_d.phase = (steps_d == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                nxt_d.val = step_val_d;
                nxt_d.cf  = step_cf_d;
                nxt_d.of  = step_msb_d ^ cur_q.sign0;
                nxt_d.rem = cur_q.rem - CW'(1);
                if (cur_q.rem == CW'(1)) nxt_d.phase = ST_DONE;
            end
            default: nxt_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: ST_IDLE, op: OP_ROL, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = (cur_q.phase == ST_RUN);
    assign done   = (cur_q.phase == ST_DONE);
    assign result = cur_q.val;
    assign cf_out = cur_q.cf;
    assign of_out = cur_q.of;
endmodule

// File: rtl/bitstep_shifter_chk.sv
module bitstep_shifter_chk #(
    parameter int DW = 16,
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result,
    input logic          wide_q
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R3

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy || done)); // R3

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (result[DW-1:NW] == '0)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(result)); // R11
endmodule

bind bitstep_shifter bitstep_shifter_chk #(.DW(DW), .NW(NW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .wide_q (cur_q.wide)
);

// File: tb/bitstep_shifter_tb_top.sv
module bitstep_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        cnt_from_reg = 1'b0;
    logic [7:0]  reg_count = 8'd0;
    logic        carry_in = 1'b0;
    logic        ovf_in = 1'b0;
    logic [15:0] operand = 16'd0;
    logic        busy;
    logic        done;
    logic [15:0] result;
    logic        cf_out;
    logic        of_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bitstep_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .op(op),
        .cnt_from_reg(cnt_from_reg), .reg_count(reg_count), .carry_in(carry_in),
        .ovf_in(ovf_in), .operand(operand), .busy(busy), .done(done),
        .result(result), .cf_out(cf_out), .of_out(of_out)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic        use_reg;
        logic [7:0]  rcnt;
        logic        cin;
        logic        oin;
        logic [15:0] opnd;
        logic [15:0] res;
        logic        cf;
        logic        of;
        logic [5:0]  lat;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h001C, 16'h0039, 1'b0, 1'b0, 6'd1},
        '{3'd3, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 16'h001C, 16'h008E, 1'b0, 1'b1, 6'd1},
        '{3'd7, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h00E0, 16'h00F0, 1'b0, 1'b0, 6'd1},
        '{3'd5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h004C, 16'h0026, 1'b0, 1'b0, 6'd1},
        '{3'd4, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h00E0, 16'h00C0, 1'b1, 1'b0, 6'd1},
        '{3'd0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 16'h8001, 16'h0003, 1'b1, 1'b1, 6'd1},
        '{3'd1, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 16'h0081, 16'h0018, 1'b0, 1'b1, 6'd4},
        '{3'd2, 1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 16'h8000, 16'h8000, 1'b0, 1'b0, 6'd17},
        '{3'd6, 1'b0, 1'b1, 8'h09, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0, 6'd9},
        '{3'd5, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 6'd31},
        '{3'd7, 1'b1, 1'b1, 8'h03, 1'b0, 1'b0, 16'h8000, 16'hF000, 1'b0, 1'b0, 6'd3},
        '{3'd0, 1'b1, 1'b1, 8'h20, 1'b1, 1'b1, 16'h1234, 16'h1234, 1'b1, 1'b1, 6'd0},
        '{3'd2, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 16'hAB1C, 16'h0039, 1'b0, 1'b0, 6'd1},
        '{3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0080, 16'h0001, 1'b1, 1'b1, 6'd1},
        '{3'd3, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 16'h0001, 16'h8000, 1'b0, 1'b1, 6'd2}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string op_req(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd6: return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic launch(input vec_t v);
        @(negedge clk);
        op = v.op; wide = v.wide; cnt_from_reg = v.use_reg; reg_count = v.rcnt;
        carry_in = v.cin; ovf_in = v.oin; operand = v.opnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat, output logic first_busy);
        lat = 0;
        first_busy = busy;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int lat;
        logic fb;
        string rq;
        launch(v);
        wait_done(lat, fb);
        rq = (v.lat == 0) ? "R9" : op_req(v.op);
        check(rq, "result", 32'(result), 32'(v.res));
        check(rq, "cf", 32'(cf_out), 32'(v.cf));
        check((v.lat == 0) ? "R9" : "R8", "of", 32'(of_out), 32'(v.of));
        check("R2_R3", "latency", 32'(lat), 32'(v.lat));
        check("R3", "busy first cycle", 32'(fb), 32'(v.lat != 0));
        check("R3", "busy with done", 32'(busy), 32'd0);
        if (!v.wide) check("R10", "upper byte", 32'(result[15:8]), 32'd0);
        @(negedge clk);
        check("R3", "done single cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "result", 32'(result), 32'd0);
        check("R1", "flags", 32'({cf_out, of_out}), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R11: start pulse during a running operation is ignored
        begin
            int lat;
            logic fb;
            launch('{3'd1, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 16'h0081, 16'h0018, 1'b0, 1'b1, 6'd4});
            operand = 16'h00FF; op = 3'd4; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(lat, fb);
            check("R11", "result", 32'(result), 32'h18);
            check("R11", "latency", 32'(lat + 1), 32'd4);
            @(negedge clk);
            check("R11", "idle after", 32'({busy, done}), 32'd0);
        end

        // R2: reg_count ignored when the count source is the fixed one
        run_vec('{3'd4, 1'b1, 1'b0, 8'h1F, 1'b0, 1'b0, 16'h4001, 16'h8002, 1'b0, 1'b1, 6'd1});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule